// File: doc/BRIEF.md
# Iterative Signed Integer Divider

This block divides one two's-complement integer by another over several clock cycles. A caller presents two operands and pulses a start strobe. The block strips the signs and divides the magnitudes by restoring shift-and-subtract. It then restores the signs and returns three results: a signed quotient, a signed remainder and the unsigned magnitude of the quotient. A one-cycle done pulse marks the moment the results become valid.

The divisor magnitude is first scaled up by doubling until it reaches half the dividend magnitude. The quotient is then built one bit per clock while the scaled divisor is halved back down, so the run time depends on the ratio of the operands. A swap input selects a second calling convention, in which the operand on the numerator port is used as the divisor. A zero divisor is detected on acceptance and returns a fixed result after a short run.

Top module: `sdiv_iter`

## Requirements
- R1: For a non-zero divisor, `quot_o` equals the magnitude quotient floor(|dividend| / |divisor|), negated when exactly one of the two operand sign bits (bit W-1) is set.
- R2: `rem_o` equals |dividend| mod |divisor|, negated under the same condition as the quotient, so its sign follows the quotient and not the dividend.
- R3: `quot_abs_o` holds the unsigned magnitude quotient, with no sign applied.
- R4: With `swap_i` low the dividend is `num_i` and the divisor is `den_i`; with `swap_i` high the two roles are exchanged. `swap_i` is sampled together with the operands.
- R5: With a zero divisor the block finishes, sets `div_zero_o`, drives `quot_o` and `quot_abs_o` to all ones and drives `rem_o` to the signed dividend as given. `div_zero_o` is low after any other division.
- R6: A `start_i` pulse while `busy_o` is high is ignored: the running division completes with its original operands.
- R7: `done_o` is high for exactly one cycle per accepted start, and never in a cycle in which `busy_o` is high. `busy_o` rises in the cycle after a start is accepted.
- R8: The result outputs change only in the cycle in which `done_o` is high, and they hold their values until the next completion.
- R9: From the accepting clock edge to `done_o` the block takes at most 2*W+4 cycles for any operands.
- R10: A start in the same cycle as `done_o` is accepted, so divisions can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| swap_i | input | 1 | Exchange dividend and divisor roles |
| num_i | input | W | Signed numerator operand |
| den_i | input | W | Signed denominator operand |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | W | Signed quotient |
| rem_o | output | W | Signed remainder |
| quot_abs_o | output | W | Unsigned quotient magnitude |
| div_zero_o | output | 1 | Last division had a zero divisor |

## Verification
A completion and a new request can fall in the same cycle: the done pulse of one division coincides with the start strobe of the next. The bench provokes this by raising start in the very cycle it first sees done. It checks the finished results in that cycle and then checks the second division against its own model value. A start that lands in the middle of a long run is also provoked. Its effect is judged by the final quotient, which must belong to the first operands.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ALIGN = 2'd1,
      ST_STEP  = 2'd2,
      ST_FIX   = 2'd3
   } sdiv_state_e;
endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
   parameter int W = 32
) (
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   input  logic         swap_i,
   output logic [W-1:0] dvd_raw_o,
   output logic [W-1:0] dvd_mag_o,
   output logic [W-1:0] dvs_mag_o,
   output logic         neg_o
);
   localparam int MSB = W - 1;

   logic [W-1:0] dvs_raw;

   always_comb begin
      dvd_raw_o = swap_i ? den_i : num_i;
      dvs_raw   = swap_i ? num_i : den_i;
      dvd_mag_o = dvd_raw_o[MSB] ? (~dvd_raw_o + 1'b1) : dvd_raw_o;
      dvs_mag_o = dvs_raw[MSB]   ? (~dvs_raw + 1'b1)   : dvs_raw;
      neg_o     = dvd_raw_o[MSB] ^ dvs_raw[MSB];
   end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core
   import sdiv_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] dvd_mag_i,
   input  logic [W-1:0] dvs_mag_i,
   output logic         accept_o,
   output logic         busy_o,
   output logic         fin_o,
   output logic         dz_o,
   output logic [W-1:0] q_mag_o,
   output logic [W-1:0] r_mag_o
);
   localparam logic [W-1:0] ZERO = '0;

   sdiv_state_e  state;
   logic [W-1:0] part_rem;
   logic [W-1:0] scaled;
   logic [W-1:0] base;
   logic [W-1:0] q_acc;
   logic         dz_q;
   logic [W-1:0] half_rem;
   logic         take;

   assign half_rem = part_rem >> 1;
   assign take     = (scaled <= part_rem);
   assign accept_o = start_i && (state == ST_IDLE);
   assign busy_o   = (state != ST_IDLE);
   assign fin_o    = (state == ST_FIX);
   assign dz_o     = dz_q;
   assign q_mag_o  = q_acc;
   assign r_mag_o  = part_rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         part_rem <= '0;
         scaled   <= '0;
         base     <= '0;
         q_acc    <= '0;
         dz_q     <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  part_rem <= dvd_mag_i;
                  scaled   <= dvs_mag_i;
                  base     <= dvs_mag_i;
                  q_acc    <= '0;
                  dz_q     <= (dvs_mag_i == ZERO);
                  state    <= (dvs_mag_i == ZERO) ? ST_FIX : ST_ALIGN;
               end
            end
            ST_ALIGN: begin
               if (scaled <= half_rem) scaled <= scaled << 1;
               if (!(scaled < half_rem)) state <= ST_STEP;
            end
            ST_STEP: begin
               q_acc <= {q_acc[W-2:0], take};
               if (take) part_rem <= part_rem - scaled;
               if (scaled == base) state <= ST_FIX;
               else scaled <= scaled >> 1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix #(
   parameter int W            = 32,
   parameter bit REM_WITH_QUO = 1'b1
) (
   input  logic [W-1:0] q_mag_i,
   input  logic [W-1:0] r_mag_i,
   input  logic [W-1:0] dvd_raw_i,
   input  logic         neg_i,
   input  logic         dz_i,
   output logic [W-1:0] quot_o,
   output logic [W-1:0] rem_o,
   output logic [W-1:0] qabs_o
);
   localparam logic [W-1:0] ALL1 = '1;

   logic [W-1:0] q_signed;
   logic         rem_neg;

   assign q_signed = neg_i ? (~q_mag_i + 1'b1) : q_mag_i;

   generate
      if (REM_WITH_QUO) begin : g_rem_quo
         assign rem_neg = neg_i;
      end else begin : g_rem_dvd
         assign rem_neg = dvd_raw_i[W-1];
      end
   endgenerate

   always_comb begin
      if (dz_i) begin
         quot_o = ALL1;
         qabs_o = ALL1;
         rem_o  = dvd_raw_i;
      end else begin
         quot_o = q_signed;
         qabs_o = q_mag_i;
         rem_o  = rem_neg ? (~r_mag_i + 1'b1) : r_mag_i;
      end
   end
endmodule

// File: rtl/sdiv_iter.sv
module sdiv_iter #(
   parameter int W            = 32,
   parameter bit REM_WITH_QUO = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         swap_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] quot_o,
   output logic [W-1:0] rem_o,
   output logic [W-1:0] quot_abs_o,
   output logic         div_zero_o
);
   generate
      if (W < 4) begin : g_bad_width
         $error("sdiv_iter: W must be at least 4");
      end
   endgenerate

   logic [W-1:0] dvd_raw_c, dvd_mag_c, dvs_mag_c;
   logic         neg_c;
   logic         accept, fin, dz;
   logic [W-1:0] q_mag, r_mag;
   logic [W-1:0] dvd_raw_q;
   logic         neg_q;
   logic [W-1:0] quot_c, rem_c, qabs_c;

   sdiv_prep #(.W(W)) u_prep (
      .num_i     (num_i),
      .den_i     (den_i),
      .swap_i    (swap_i),
      .dvd_raw_o (dvd_raw_c),
      .dvd_mag_o (dvd_mag_c),
      .dvs_mag_o (dvs_mag_c),
      .neg_o     (neg_c)
   );

   sdiv_core #(.W(W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .dvd_mag_i (dvd_mag_c),
      .dvs_mag_i (dvs_mag_c),
      .accept_o  (accept),
      .busy_o    (busy_o),
      .fin_o     (fin),
      .dz_o      (dz),
      .q_mag_o   (q_mag),
      .r_mag_o   (r_mag)
   );

   sdiv_fix #(.W(W), .REM_WITH_QUO(REM_WITH_QUO)) u_fix (
      .q_mag_i   (q_mag),
      .r_mag_i   (r_mag),
      .dvd_raw_i (dvd_raw_q),
      .neg_i     (neg_q),
      .dz_i      (dz),
      .quot_o    (quot_c),
      .rem_o     (rem_c),
      .qabs_o    (qabs_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvd_raw_q  <= '0;
         neg_q      <= 1'b0;
         done_o     <= 1'b0;
         quot_o     <= '0;
         rem_o      <= '0;
         quot_abs_o <= '0;
         div_zero_o <= 1'b0;
      end else begin
         done_o <= fin;
         if (accept) begin
            dvd_raw_q <= dvd_raw_c;
            neg_q     <= neg_c;
         end
         if (fin) begin
            quot_o     <= quot_c;
            rem_o      <= rem_c;
            quot_abs_o <= qabs_c;
            div_zero_o <= dz;
         end
      end
   end
endmodule

// File: rtl/sdiv_iter_chk.sv
module sdiv_iter_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [W-1:0] quot_o,
   input logic [W-1:0] rem_o,
   input logic [W-1:0] quot_abs_o,
   input logic         div_zero_o
);
   localparam int LAT_MAX = 2 * W + 4;
   localparam int CW      = $clog2(LAT_MAX + 2) + 1;

   logic [CW-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_cnt <= '0;
      else if (!busy_o) busy_cnt <= '0;
      else if (busy_cnt < CW'(LAT_MAX + 1)) busy_cnt <= busy_cnt + 1'b1;
   end

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   p_start_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);
   p_hold_results_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(quot_abs_o)
                   && $stable(div_zero_o)));
   p_zero_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && div_zero_o) |-> ((&quot_o) && (&quot_abs_o)));
   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= CW'(LAT_MAX));
endmodule

bind sdiv_iter sdiv_iter_chk #(.W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .quot_o     (quot_o),
   .rem_o      (rem_o),
   .quot_abs_o (quot_abs_o),
   .div_zero_o (div_zero_o)
);

// File: tb/sdiv_iter_tb.sv
module sdiv_iter_tb_top;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         swap_i = 1'b0;
   logic [W-1:0] num_i = '0;
   logic [W-1:0] den_i = '0;
   logic         busy_o, done_o, div_zero_o;
   logic [W-1:0] quot_o, rem_o, quot_abs_o;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #2 clk = ~clk;

   sdiv_iter #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .swap_i(swap_i),
      .num_i(num_i), .den_i(den_i), .busy_o(busy_o), .done_o(done_o),
      .quot_o(quot_o), .rem_o(rem_o), .quot_abs_o(quot_abs_o),
      .div_zero_o(div_zero_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   typedef struct {
      logic [W-1:0] q, r, qa;
      logic         dz;
   } exp_t;

   function automatic logic [W-1:0] mag(input logic [W-1:0] v);
      return v[W-1] ? (~v + 1'b1) : v;
   endfunction

   function automatic exp_t model(input logic [W-1:0] n, input logic [W-1:0] d,
                                  input logic sw);
      exp_t e;
      logic [W-1:0] a, b, qm, rm;
      logic neg;
      a = sw ? d : n;
      b = sw ? n : d;
      if (b == '0) begin
         e.q = '1; e.qa = '1; e.r = a; e.dz = 1'b1;
      end else begin
         qm = mag(a) / mag(b);
         rm = mag(a) % mag(b);
         neg = a[W-1] ^ b[W-1];
         e.q  = neg ? (~qm + 1'b1) : qm;
         e.r  = neg ? (~rm + 1'b1) : rm;
         e.qa = qm;
         e.dz = 1'b0;
      end
      return e;
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_res(input string tq, input exp_t e);
      chk({tq, " quot R1"}, quot_o, e.q);
      chk({tq, " rem R2"}, rem_o, e.r);
      chk({tq, " qabs R3"}, quot_abs_o, e.qa);
      chk({tq, " dz R5"}, W'(div_zero_o), W'(e.dz));
   endtask

   task automatic launch(input logic [W-1:0] n, input logic [W-1:0] d, input logic sw);
      num_i = n; den_i = d; swap_i = sw; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(output int lat);
      lat = 1;
      while (!done_o && lat < 400) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic run_op(input string tq, input logic [W-1:0] n, input logic [W-1:0] d,
                         input logic sw);
      int lat;
      exp_t e;
      e = model(n, d, sw);
      launch(n, d, sw);
      wait_done(lat);
      check_res(tq, e);
      chk({tq, " latency R9"}, W'(lat <= 2 * W + 4), W'(1));
      @(negedge clk);
   endtask

   initial begin
      int lat;
      exp_t e1, e2;
      void'($urandom(32'h5D1C0));
      repeat (3) @(negedge clk);
      chk("reset busy R7", W'(busy_o), '0);
      chk("reset done R7", W'(done_o), '0);
      chk("reset quot R8", quot_o, '0);
      rst_n = 1'b1;
      @(negedge clk);

      run_op("pos/pos", 32'd7, 32'd2, 1'b0);
      run_op("neg/pos", -32'sd7, 32'd2, 1'b0);
      run_op("pos/neg", 32'd7, -32'sd2, 1'b0);
      run_op("neg/neg", -32'sd7, -32'sd2, 1'b0);
      run_op("exact", 32'd100, 32'd10, 1'b0);
      run_op("small dvd", 32'd3, 32'd9, 1'b0);
      run_op("zero dvd", 32'd0, -32'sd5, 1'b0);
      run_op("min/-1", 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
      run_op("min/1", 32'h8000_0000, 32'd1, 1'b0);
      run_op("max/1", 32'h7FFF_FFFF, 32'd1, 1'b0);
      run_op("swap R4", 32'd3, 32'd20, 1'b1);
      run_op("swap neg R4", -32'sd6, 32'd25, 1'b1);
      run_op("div zero R5", -32'sd9, 32'd0, 1'b0);
      run_op("div zero swap R5", 32'd0, 32'd44, 1'b1);
      run_op("after zero R5", 32'd44, 32'd4, 1'b0);

      // R6: start during a long run is ignored
      e1 = model(32'h7FFF_FFFF, 32'd1, 1'b0);
      launch(32'h7FFF_FFFF, 32'd1, 1'b0);
      repeat (5) @(negedge clk);
      launch(32'd9, 32'd3, 1'b0);
      chk("busy after ignored start R6", W'(busy_o), W'(1));
      wait_done(lat);
      chk("ignored start quot R6", quot_o, e1.q);
      chk("ignored start rem R6", rem_o, e1.r);

      // R10: new start in the done cycle
      e2 = model(-32'sd1000, 32'd7, 1'b0);
      num_i = -32'sd1000; den_i = 32'd7; swap_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("b2b accepted R10", W'(busy_o), W'(1));
      wait_done(lat);
      check_res("b2b R10", e2);

      // R8: results hold without a start
      num_i = 32'd5; den_i = 32'd0; swap_i = 1'b1;
      repeat (6) @(negedge clk);
      chk("hold quot R8", quot_o, e2.q);
      chk("hold rem R8", rem_o, e2.r);
      chk("done single R7", W'(done_o), '0);

      for (int i = 0; i < 60; i++) begin
         logic [W-1:0] n, d;
         n = $urandom();
         d = $urandom();
         case (i % 4)
            0: d = d >> 24;
            1: d = {{(W-8){d[W-1]}}, d[7:0]};
            2: n = n >> 20;
            default: ;
         endcase
         run_op("random", n, d, 1'($urandom() & 1));
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule